// File: doc/BRIEF.md
# Nibble-Memory Call Stack Controller

This block keeps subroutine return addresses for a small processor whose data memory is four bits wide. It holds a hidden depth counter and stores each 12-bit return address as a frame of three nibbles in a dedicated sixteen-nibble page of data memory. A push strobe writes a frame and deepens the stack. A pop strobe reads the top frame back, reassembles the address and, in the same operation, writes a 4-bit literal into result register location 0x00. The processor uses this literal to return a value from a table lookup.

All memory traffic goes through a single nibble-wide port. Writes take effect at the clock edge. Reads return data one cycle after the read enable. While an operation is in progress, busy is high and new strobes are ignored. Two faults are possible: a push on a full stack and a pop on an empty one. Either fault stops the controller and presents a distinct 3-bit code. The controller stays stopped until reset.

Top module: `nibble_call_stack`

## Requirements
- R1: Frame k (k = stack depth before the push, 0 to 4) occupies data addresses 0x10+3k to 0x12+3k. The low nibble of the address goes at 0x10+3k, the middle nibble at the next address, and the high nibble at the one after.
- R2: An accepted push writes its three nibbles in three consecutive cycles, starting the cycle after the strobe. busy is high for exactly those three cycles, and the depth grows by one.
- R3: An accepted pop reads the top frame and then spends one further cycle presenting the reassembled address on ret_addr, with ret_valid high for that single cycle. busy is high for four cycles. Addresses come back in last-in, first-out order.
- R4: In the ret_valid cycle of a pop, the controller writes the ret_literal value captured with the pop strobe to data address 0x00.
- R5: The depth never exceeds five frames, and the controller never reads or writes address 0x1F.
- R6: A push while five frames are held does not write memory. It sets halted and drives err_code to 3'b110 from the next cycle.
- R7: A pop while the stack is empty does not access memory. It sets halted and drives err_code to 3'b111 from the next cycle.
- R8: While halted, push and pop strobes are ignored and halted and err_code hold their values. Reset clears halted, returns err_code to 3'b000 and empties the stack.
- R9: Strobes that arrive while busy is high are ignored.
- R10: When push_req and pop_req are high together while idle, only the push is performed.
- R11: When no operation is in progress, both memory enables are low and busy and ret_valid are low. err_code is 3'b000 whenever halted is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push strobe, one cycle |
| pop_req | input | 1 | Pop strobe, one cycle |
| push_addr | input | 12 | Return address to store on push |
| ret_literal | input | 4 | Value written to address 0x00 on pop |
| ret_addr | output | 12 | Reassembled address, valid with ret_valid |
| ret_valid | output | 1 | One-cycle pulse that ends a pop |
| busy | output | 1 | Operation in progress |
| halted | output | 1 | Fault latched |
| err_code | output | 3 | 000 none, 110 overflow, 111 underflow |
| mem_addr | output | 8 | Data memory address |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_wr_data | output | 4 | Data memory write nibble |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_rd_data | input | 4 | Read nibble, one cycle after mem_rd_en |

## Verification
The hardest state to reach from the ports is a stack holding five live frames whose address 0x1F has still never been accessed, followed by an overflow push that must leave memory untouched. The stimulus nests five distinct addresses and unwinds them in reverse order. It then refills the stack and issues a sixth push, while a bench memory model counts every access and tracks address 0x1F separately. Strobes that land in the middle of a push are exercised by pulsing a second push and a pop during busy. The stack is then drained until it underflows, which shows that neither ignored strobe changed the depth.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

    localparam int NIB_W   = 4;
    localparam int DADDR_W = 8;
    localparam logic [DADDR_W-1:0] RESULT_ADDR = 8'h00;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_READ,
        SQ_FIN
    } seq_st_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'b000,
        FLT_OVER  = 3'b110,
        FLT_UNDER = 3'b111
    } fault_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [DADDR_W-1:0] addr;
        logic [NIB_W-1:0]   data;
    } mem_req_t;

    function automatic logic [DADDR_W-1:0] frame_base(int page, int nibs, int slot);
        return DADDR_W'(page + nibs * slot);
    endfunction

endpackage

// File: rtl/nstk_ptr.sv
module nstk_ptr #(
    parameter int MAX_LEVELS = 5,
    localparam int SP_W = $clog2(MAX_LEVELS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp,
    output logic            full,
    output logic            empty
);

    always_ff @(posedge clk) begin
        if (rst)
            sp <= '0;
        else if (inc)
            sp <= sp + 1'b1;
        else if (dec)
            sp <= sp - 1'b1;
    end

    assign full  = (sp == SP_W'(MAX_LEVELS));
    assign empty = (sp == '0);

    // R5: depth bounded by the level limit
    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(MAX_LEVELS));

    // R5: no increment at the limit, no decrement at zero
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        !(inc && full) && !(dec && empty));

endmodule

// File: rtl/nstk_fault.sv
module nstk_fault
    import nstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_over,
    input  logic       set_under,
    output logic       halted,
    output logic [2:0] code
);

    fault_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
            code_q <= FLT_NONE;
        end else if (!halted) begin
            if (set_over) begin
                halted <= 1'b1;
                code_q <= FLT_OVER;
            end else if (set_under) begin
                halted <= 1'b1;
                code_q <= FLT_UNDER;
            end
        end
    end

    assign code = code_q;

    // R8: halt and code latched until reset
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(code));

    // R6, R7: only the two fault codes while halted
    p_code_value_r6: assert property (@(posedge clk) disable iff (rst)
        halted |-> (code == 3'b110 || code == 3'b111));

    // R11: quiet code when running
    p_code_clear_r11: assert property (@(posedge clk) disable iff (rst)
        !halted |-> code == 3'b000);

endmodule

// File: rtl/nstk_seq.sv
module nstk_seq
    import nstk_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MAX_LEVELS = 5,
    parameter int STACK_BASE = 16,
    localparam int NIBS  = ADDR_W / NIB_W,
    localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_push,
    input  logic               start_pop,
    input  logic [DADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0]  push_addr,
    input  logic [NIB_W-1:0]   literal,
    input  logic [NIB_W-1:0]   mem_rd_data,
    output mem_req_t           mem_req,
    output logic               push_done,
    output logic               busy,
    output logic [ADDR_W-1:0]  ret_addr,
    output logic               ret_valid
);

    seq_st_e                       state_q;
    logic [IDX_W-1:0]              idx_q;
    logic [DADDR_W-1:0]            base_q;
    logic [ADDR_W-1:0]             addr_q;
    logic [NIB_W-1:0]              lit_q;
    logic [NIBS-2:0][NIB_W-1:0]    nib_q;
    logic [NIB_W-1:0]              wr_nib;
    logic                          last_idx;

    assign last_idx = (idx_q == IDX_W'(NIBS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            addr_q  <= '0;
            lit_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    idx_q <= '0;
                    if (start_push) begin
                        state_q <= SQ_WRITE;
                        base_q  <= base_in;
                        addr_q  <= push_addr;
                    end else if (start_pop) begin
                        state_q <= SQ_READ;
                        base_q  <= base_in;
                        lit_q   <= literal;
                    end
                end
                SQ_WRITE: begin
                    if (last_idx) state_q <= SQ_IDLE;
                    else          idx_q   <= idx_q + 1'b1;
                end
                SQ_READ: begin
                    if (last_idx) state_q <= SQ_FIN;
                    else          idx_q   <= idx_q + 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // capture of nibbles returned one cycle after each read
    for (genvar g = 0; g < NIBS - 1; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)
                nib_q[g] <= '0;
            else if (state_q == SQ_READ && idx_q == IDX_W'(g + 1))
                nib_q[g] <= mem_rd_data;
        end
    end

    always_comb begin
        wr_nib = '0;
        for (int i = 0; i < NIBS; i++)
            if (idx_q == IDX_W'(i)) wr_nib = addr_q[i*NIB_W +: NIB_W];
    end

    always_comb begin
        mem_req = '0;
        case (state_q)
            SQ_WRITE: begin
                mem_req.wr   = 1'b1;
                mem_req.addr = base_q + DADDR_W'(idx_q);
                mem_req.data = wr_nib;
            end
            SQ_READ: begin
                mem_req.rd   = 1'b1;
                mem_req.addr = base_q + DADDR_W'(idx_q);
            end
            SQ_FIN: begin
                mem_req.wr   = 1'b1;
                mem_req.addr = RESULT_ADDR;
                mem_req.data = lit_q;
            end
            default: mem_req = '0;
        endcase
    end

    assign ret_addr  = {mem_rd_data, nib_q};
    assign ret_valid = (state_q == SQ_FIN);
    assign busy      = (state_q != SQ_IDLE);
    assign push_done = (state_q == SQ_WRITE) && last_idx;

    // R5: accesses stay inside the used frames or the result register
    p_access_window_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req.wr || mem_req.rd) |->
            (mem_req.addr == RESULT_ADDR) ||
            (mem_req.addr >= DADDR_W'(STACK_BASE) &&
             mem_req.addr <  DADDR_W'(STACK_BASE + NIBS * MAX_LEVELS)));

    // R3: return pulse lasts one cycle
    p_ret_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> !ret_valid);

    // R4: literal write coincides with the return pulse
    p_lit_write_r4: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> mem_req.wr && mem_req.addr == RESULT_ADDR);

endmodule

// File: rtl/nibble_call_stack.sv
module nibble_call_stack
    import nstk_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MAX_LEVELS = 5,
    parameter int STACK_BASE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push_req,
    input  logic                pop_req,
    input  logic [ADDR_W-1:0]   push_addr,
    input  logic [NIB_W-1:0]    ret_literal,
    output logic [ADDR_W-1:0]   ret_addr,
    output logic                ret_valid,
    output logic                busy,
    output logic                halted,
    output logic [2:0]          err_code,
    output logic [DADDR_W-1:0]  mem_addr,
    output logic                mem_wr_en,
    output logic [NIB_W-1:0]    mem_wr_data,
    output logic                mem_rd_en,
    input  logic [NIB_W-1:0]    mem_rd_data
);

    localparam int NIBS = ADDR_W / NIB_W;
    localparam int SP_W = $clog2(MAX_LEVELS + 1);

    logic [SP_W-1:0]    sp;
    logic               full, empty, idle;
    logic               acc_push, acc_pop, ovf, unf, push_done;
    logic [DADDR_W-1:0] base_sel;
    mem_req_t           mem_req;

    assign idle     = !busy && !halted;
    assign acc_push = idle && push_req && !full;
    assign ovf      = idle && push_req && full;
    assign acc_pop  = idle && !push_req && pop_req && !empty;
    assign unf      = idle && !push_req && pop_req && empty;

    assign base_sel = push_req ? frame_base(STACK_BASE, NIBS, int'(sp))
                               : frame_base(STACK_BASE, NIBS, int'(sp) - 1);

    nstk_ptr #(.MAX_LEVELS(MAX_LEVELS)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .inc   (push_done),
        .dec   (acc_pop),
        .sp    (sp),
        .full  (full),
        .empty (empty)
    );

    nstk_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .set_over  (ovf),
        .set_under (unf),
        .halted    (halted),
        .code      (err_code)
    );

    nstk_seq #(
        .ADDR_W     (ADDR_W),
        .MAX_LEVELS (MAX_LEVELS),
        .STACK_BASE (STACK_BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_push  (acc_push),
        .start_pop   (acc_pop),
        .base_in     (base_sel),
        .push_addr   (push_addr),
        .literal     (ret_literal),
        .mem_rd_data (mem_rd_data),
        .mem_req     (mem_req),
        .push_done   (push_done),
        .busy        (busy),
        .ret_addr    (ret_addr),
        .ret_valid   (ret_valid)
    );

    assign mem_addr    = mem_req.addr;
    assign mem_wr_en   = mem_req.wr;
    assign mem_wr_data = mem_req.data;
    assign mem_rd_en   = mem_req.rd;

    // R8: halted controller is silent
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_wr_en && !mem_rd_en && !busy);

    // R6: push on a full stack stops with the overflow code
    p_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push_req && !busy && !halted && full) |=> halted && err_code == 3'b110);

    // R7: pop on an empty stack stops with the underflow code
    p_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !busy && !halted && empty)
            |=> halted && err_code == 3'b111);

    // R11: no memory traffic while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_wr_en && !mem_rd_en && !ret_valid);

endmodule

// File: tb/sim_nibble_call_stack.sv
`timescale 1ns/100ps
module sim_nibble_call_stack;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_req, pop_req;
    logic [11:0] push_addr;
    logic [3:0]  ret_literal;
    logic [11:0] ret_addr;
    logic        ret_valid, busy, halted;
    logic [2:0]  err_code;
    logic [7:0]  mem_addr;
    logic        mem_wr_en, mem_rd_en;
    logic [3:0]  mem_wr_data, mem_rd_data;

    always #2.5 clk = ~clk;

    nibble_call_stack u0 (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_addr(push_addr), .ret_literal(ret_literal),
        .ret_addr(ret_addr), .ret_valid(ret_valid), .busy(busy),
        .halted(halted), .err_code(err_code), .mem_addr(mem_addr),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data)
    );

    // memory model: write at edge, read data one cycle later
    logic [3:0] mem [256];
    int acc_cnt  = 0;
    int acc_1f   = 0;
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
        if (mem_wr_en || mem_rd_en) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_addr == 8'h1F) acc_1f <= acc_1f + 1;
        end
    end

    int total = 0;
    int errs  = 0;
    bit done  = 0;
    logic [11:0] model_stk[$];
    logic [11:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each return against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && ret_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected return", int'(ret_addr), 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk(ret_addr == e, "R3 return address", int'(ret_addr), int'(e));
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1; push_req = 0; pop_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_stk.delete();
        @(negedge clk);
    endtask

    task automatic do_push(input logic [11:0] a, input bit expect_ok);
        int n = 0;
        push_req = 1; push_addr = a;
        @(negedge clk);
        push_req = 0;
        while (busy) begin n++; @(negedge clk); end
        if (expect_ok) begin
            chk(n == 3, "R2 push busy cycles", n, 3);
            model_stk.push_back(a);
        end
    endtask

    task automatic do_pop(input logic [3:0] lit);
        int n = 0;
        pop_req = 1; ret_literal = lit;
        @(negedge clk);
        pop_req = 0; ret_literal = 4'h0;
        exp_q.push_back(model_stk.pop_back());
        while (busy) begin n++; @(negedge clk); end
        chk(n == 4, "R3 pop busy cycles", n, 4);
        chk(mem[0] == lit, "R4 literal in 0x00", int'(mem[0]), int'(lit));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        int a0;
        logic [11:0] addrs [5];
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
        mem[8'h1F] = 4'h5;
        mem_rd_data = 4'h0;
        push_addr = 0; ret_literal = 0;
        addrs[0] = 12'h3A1; addrs[1] = 12'hF07; addrs[2] = 12'h5C2;
        addrs[3] = 12'h0E9; addrs[4] = 12'hB64;

        do_reset();
        // R11 / R8: reset state
        chk(!busy && !halted && !ret_valid, "R11 idle after reset", {busy, halted, ret_valid}, 0);
        chk(err_code == 3'b000, "R8 code after reset", err_code, 0);
        chk(!mem_wr_en && !mem_rd_en, "R11 no traffic idle", {mem_wr_en, mem_rd_en}, 0);

        // R1: frame layout low-first
        do_push(12'hABC, 1);
        chk(mem[8'h10] == 4'hC, "R1 low nibble", mem[8'h10], 12);
        chk(mem[8'h11] == 4'hB, "R1 mid nibble", mem[8'h11], 11);
        chk(mem[8'h12] == 4'hA, "R1 high nibble", mem[8'h12], 10);
        do_pop(4'h9);

        // R3 / R5: nest five, unwind LIFO
        for (int i = 0; i < 5; i++) do_push(addrs[i], 1);
        chk({mem[8'h1E], mem[8'h1D], mem[8'h1C]} == addrs[4], "R1 fifth frame",
            int'({mem[8'h1E], mem[8'h1D], mem[8'h1C]}), int'(addrs[4]));
        chk(!halted, "R5 five levels allowed", halted, 0);
        for (int i = 0; i < 5; i++) do_pop(4'(i + 1));
        chk(exp_q.size() == 0, "R3 all returns seen", exp_q.size(), 0);

        // R6: overflow
        for (int i = 0; i < 5; i++) do_push(addrs[i] ^ 12'h111, 1);
        a0 = acc_cnt;
        do_push(12'h777, 0);
        chk(halted, "R6 halted on overflow", halted, 1);
        chk(err_code == 3'b110, "R6 overflow code", err_code, 6);
        chk(acc_cnt == a0, "R6 no memory write", acc_cnt, a0);
        chk(mem[8'h1F] == 4'h5 && acc_1f == 0, "R5 0x1F untouched", acc_1f, 0);

        // R8: ignored while halted
        pop_req = 1; @(negedge clk); pop_req = 0;
        push_req = 1; @(negedge clk); push_req = 0;
        repeat (5) @(negedge clk);
        chk(acc_cnt == a0 && !busy, "R8 no activity halted", acc_cnt, a0);
        chk(halted && err_code == 3'b110, "R8 code held", err_code, 6);

        // R7 / R8: reset empties; pop underflows
        do_reset();
        chk(!halted && err_code == 3'b000, "R8 reset clears fault", err_code, 0);
        a0 = acc_cnt;
        pop_req = 1; @(negedge clk); pop_req = 0;
        chk(halted && err_code == 3'b111, "R7 underflow code", err_code, 7);
        chk(acc_cnt == a0, "R7 no memory access", acc_cnt, a0);

        // R10: simultaneous push and pop
        do_reset();
        pop_req = 1;
        do_push(12'h123, 1);
        chk(!halted, "R10 push taken over pop", halted, 0);
        do_pop(4'hE);

        // R9: strobes during busy ignored
        push_req = 1; push_addr = 12'h456;
        @(negedge clk);
        push_addr = 12'h789; pop_req = 1;
        @(negedge clk);
        push_req = 0; pop_req = 0;
        while (busy) @(negedge clk);
        model_stk.push_back(12'h456);
        do_pop(4'h2);
        chk(exp_q.size() == 0, "R9 single frame returned", exp_q.size(), 0);
        pop_req = 1; @(negedge clk); pop_req = 0;
        chk(err_code == 3'b111, "R9 stack emptied after one pop", err_code, 7);
        chk(acc_1f == 0, "R5 0x1F never accessed", acc_1f, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

endmodule